// File: doc/BRIEF.md
# Periodic Interval Timer

This block is a memory-mapped timer that produces a steady periodic event. A fixed prescaler divides the master clock by sixteen. Each prescaled tick advances a 20-bit counter. When the counter reaches the programmed limit, it returns to zero on the next tick. That return is one completed period. Each completed period sets a status flag and adds one to a 12-bit period tally. The tally saturates and does not roll over. A level interrupt is raised while the flag is set and interrupts are enabled.

Software reaches the block through a simple single-cycle register bus with four word registers in a 16-byte window. Two of these registers give a view of the counter and the tally:
- the acknowledge view, which clears the tally and the flag when it is read;
- the peek view, which leaves all state untouched.

Clearing the enable bit does not stop the counter at once. The counter runs on to its next return to zero and then stays there. Software can poll for a zero counter before it programs a fresh start.

Top module: `pit_timer`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: While running, the counter increases by one every 16 clock cycles. When a tick finds the counter equal to the programmed limit, the counter goes to zero instead, and that tick completes one period.
- R3: The mode register at offset 0x0 holds the limit (period minus one) in bits 19:0, the enable bit in bit 24 and the interrupt-enable bit in bit 25. It reads back exactly these fields, and every other bit reads zero.
- R4: The value register (offset 0x8) and the image register (offset 0xC) both return the counter in bits 19:0 and the period tally in bits 31:20. Reading the image register changes no state.
- R5: Reading the value register clears the period tally and the status flag.
- R6: Bit 0 of the status register (offset 0x4) is set by every completed period and stays set until it is acknowledged.
- R7: `irq` is high exactly when the status flag and the interrupt-enable bit are both set. The counter keeps running with interrupts disabled.
- R8: After enable is cleared, the counter keeps counting up to its next return to zero, completes that period, and then stays at zero.
- R9: The period tally stops at 4095 and does not wrap.
- R10: If a period completes in the same cycle as a value-register read, the read returns the fields from before the tick. Afterwards the tally is 1 and the flag is set.
- R11: Writes to the status, value and image offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset inside the window (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| irq | output | 1 | Level interrupt |

## Verification
Two events can fall in the same clock edge: a completed period and an acknowledging read of the value register. The bench makes them coincide by counting edges from the enabling write. It times a value read so that its active edge is the 128th, which is the tick that ends the second period of a four-tick period. The bench judges the outcome three ways: the returned word must still show the pre-tick counter and a tally of 1, the image register must then show tally 1 with the counter at zero, and the flag and interrupt must stay set.

// File: rtl/pit_pkg.sv
package pit_pkg;
   // word index decoded from bus_addr[3:2]
   localparam logic [1:0] IDX_MODE  = 2'd0;
   localparam logic [1:0] IDX_STAT  = 2'd1;
   localparam logic [1:0] IDX_VALUE = 2'd2;
   localparam logic [1:0] IDX_IMAGE = 2'd3;
   localparam int         BUS_W     = 32;
endpackage

// File: rtl/pit_prescale.sv
module pit_prescale #(
   parameter int DIV = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int  PW   = (DIV > 1) ? $clog2(DIV) : 1;
   localparam bit  POW2 = ((1 << PW) == DIV);
   localparam logic [PW-1:0] LAST = PW'(DIV - 1);

   logic [PW-1:0] q;

   generate
      if (DIV < 2) begin : g_bad_div
         $error("pit_prescale: DIV must be at least 2");
      end
      if (POW2) begin : g_pow2
         // natural binary wrap, no compare needed for the reload
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    q <= '0;
            else if (!run) q <= '0;
            else           q <= q + 1'b1;
         end
      end else begin : g_modulo
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         q <= '0;
            else if (!run)      q <= '0;
            else if (q == LAST) q <= '0;
            else                q <= q + 1'b1;
         end
      end
   endgenerate

   assign tick = run && (q == LAST);

   AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R2
endmodule

// File: rtl/pit_core.sv
module pit_core #(
   parameter int CNT_W  = 20,
   parameter int PCNT_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              tick,
   input  logic [CNT_W-1:0]  limit,
   input  logic              ack,
   output logic [CNT_W-1:0]  cnt,
   output logic [PCNT_W-1:0] pcnt,
   output logic              flag,
   output logic              busy
);
   localparam logic [PCNT_W-1:0] PCNT_MAX = '1;
   localparam logic [PCNT_W-1:0] PCNT_ONE = PCNT_W'(1);

   logic wrap;

   assign busy = en || (cnt != '0);
   assign wrap = tick && (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (wrap) cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         pcnt <= '0;
      else if (ack)                       pcnt <= wrap ? PCNT_ONE : '0;
      else if (wrap && pcnt != PCNT_MAX)  pcnt <= pcnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flag <= 1'b0;
      else if (wrap) flag <= 1'b1;
      else if (ack)  flag <= 1'b0;
   end

   AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt != limit) |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R2
   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt == limit) |=> (cnt == '0) && flag); // R6
   AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !(tick && cnt == limit)) |=> (pcnt == '0) && !flag); // R5
   AST_ACK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && tick && cnt == limit) |=> (pcnt == PCNT_ONE) && flag); // R10
   AST_PCNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      (pcnt == PCNT_MAX && !ack) |=> pcnt == PCNT_MAX); // R9
   AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && cnt == '0) |=> cnt == '0); // R8
endmodule

// File: rtl/pit_timer.sv
module pit_timer #(
   parameter int CNT_W    = 20,
   parameter int PCNT_W   = 12,
   parameter int PRESCALE = 16,
   parameter int EN_POS   = 24,
   parameter int IE_POS   = 25
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_sel,
   input  logic        bus_wr,
   input  logic [3:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        irq
);
   import pit_pkg::*;

   localparam logic [BUS_W-1:0] USED_MASK =
      ((BUS_W'(1) << CNT_W) - 1) | (BUS_W'(1) << EN_POS) | (BUS_W'(1) << IE_POS);

   generate
      if (CNT_W + PCNT_W != BUS_W) begin : g_bad_split
         $error("pit_timer: counter and tally must fill one bus word");
      end
      if (EN_POS < CNT_W || IE_POS < CNT_W || EN_POS == IE_POS ||
          EN_POS >= BUS_W || IE_POS >= BUS_W) begin : g_bad_bits
         $error("pit_timer: control bit positions overlap");
      end
   endgenerate

   logic [CNT_W-1:0]  mode_lim;
   logic              mode_en, mode_ie;
   logic [CNT_W-1:0]  cnt;
   logic [PCNT_W-1:0] pcnt;
   logic              flag, busy, tick;
   logic              hit, wr_mode, rd_value;
   logic [1:0]        idx;
   logic              unused_wdata;

   assign idx      = bus_addr[3:2];
   assign hit      = bus_sel && (bus_addr[1:0] == 2'b00);
   assign wr_mode  = hit && bus_wr && (idx == IDX_MODE);
   assign rd_value = hit && !bus_wr && (idx == IDX_VALUE);
   assign unused_wdata = ^(bus_wdata & ~USED_MASK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_lim <= '0;
         mode_en  <= 1'b0;
         mode_ie  <= 1'b0;
      end else if (wr_mode) begin
         mode_lim <= bus_wdata[CNT_W-1:0];
         mode_en  <= bus_wdata[EN_POS];
         mode_ie  <= bus_wdata[IE_POS];
      end
   end

   pit_prescale #(.DIV(PRESCALE)) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (busy),
      .tick (tick)
   );

   pit_core #(.CNT_W(CNT_W), .PCNT_W(PCNT_W)) u_core (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (mode_en),
      .tick (tick),
      .limit(mode_lim),
      .ack  (rd_value),
      .cnt  (cnt),
      .pcnt (pcnt),
      .flag (flag),
      .busy (busy)
   );

   always_comb begin
      bus_rdata = '0;
      unique case (idx)
         IDX_MODE: begin
            bus_rdata[CNT_W-1:0] = mode_lim;
            bus_rdata[EN_POS]    = mode_en;
            bus_rdata[IE_POS]    = mode_ie;
         end
         IDX_STAT:  bus_rdata[0] = flag;
         default:   bus_rdata = {pcnt, cnt};
      endcase
   end

   assign irq = flag && mode_ie;

   AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt == mode_lim && mode_ie && !wr_mode) |=> irq); // R7
   AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_mode |=> $stable({mode_lim, mode_en, mode_ie})); // R11
endmodule

// File: tb/pit_timer_test.sv
`timescale 1ns/1ps
module pit_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;
   int          checks = 0, errors = 0;
   bit          done = 0;

   localparam logic [31:0] EN = 32'h0100_0000;
   localparam logic [31:0] IE = 32'h0200_0000;

   always #10 clk = ~clk;

   pit_timer uut (.clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata, .irq);

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk); #1;
      bus_sel = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      do_reset();
      rd(4'h0, d); check("R1 mode", d, 0);
      rd(4'h4, d); check("R1 status", d, 0);
      rd(4'h8, d); check("R1 value", d, 0);
      rd(4'hC, d); check("R1 image", d, 0);
      check("R1 irq", {31'b0, irq}, 0);
   endtask

   task automatic t_mode();
      logic [31:0] d;
      do_reset();
      wr(4'h0, 32'h0300_0005); rd(4'h0, d); check("R3 fields", d, 32'h0300_0005);
      wr(4'h0, 32'hFCFF_FFFF); rd(4'h0, d); check("R3 masked", d, 32'h000F_FFFF);
   endtask

   task automatic t_period();
      logic [31:0] d;
      do_reset();
      wr(4'h0, EN | 3);                       // enable edge = 0
      repeat (40) @(posedge clk);             // after edge 40: two ticks
      rd(4'hC, d); check("R2 count 2", d, 32'h0000_0002);
      rd(4'h4, d); check("R6 no flag yet", d, 0);
      repeat (46) @(posedge clk);             // after edge 88: five ticks
      rd(4'hC, d); check("R2 wrap tally", d, 32'h0010_0001);
      rd(4'h4, d); check("R6 flag set", d, 1);
      check("R7 irq masked", {31'b0, irq}, 0);
      rd(4'hC, d); check("R4 image no side effect", d, 32'h0010_0001);
      wr(4'h0, EN | IE | 3);
      check("R7 irq on enable", {31'b0, irq}, 1);
      rd(4'h8, d); check("R4 value fields", d, 32'h0010_0001);
      rd(4'hC, d); check("R5 tally cleared", d, 32'h0000_0001);
      rd(4'h4, d); check("R5 flag cleared", d, 0);
      check("R7 irq cleared", {31'b0, irq}, 0);
   endtask

   task automatic t_coincide();
      logic [31:0] d;
      do_reset();
      wr(4'h0, EN | IE | 3);
      repeat (127) @(posedge clk);            // read edge is 128 = eighth tick
      rd(4'h8, d); check("R10 old fields", d, 32'h0010_0003);
      rd(4'hC, d); check("R10 tally one", d, 32'h0010_0000);
      rd(4'h4, d); check("R10 flag kept", d, 1);
      check("R10 irq kept", {31'b0, irq}, 1);
   endtask

   task automatic t_disable();
      logic [31:0] d;
      do_reset();
      wr(4'h0, EN | 3);
      repeat (20) @(posedge clk);
      wr(4'h0, 3);                            // disable at edge 21, count 1
      repeat (18) @(posedge clk);
      rd(4'hC, d); check("R8 runs on", d, 32'h0000_0002);
      repeat (40) @(posedge clk);
      rd(4'hC, d); check("R8 stopped at zero", d, 32'h0010_0000);
      repeat (100) @(posedge clk);
      rd(4'hC, d); check("R8 stays zero", d, 32'h0010_0000);
      // R11: writes to read-only offsets
      wr(4'h8, 32'h0); wr(4'h4, 32'h0); wr(4'hC, 32'hFFFF_FFFF);
      rd(4'hC, d); check("R11 image kept", d, 32'h0010_0000);
      rd(4'h4, d); check("R11 flag kept", d, 1);
      rd(4'h0, d); check("R11 mode kept", d, 32'h0000_0003);
   endtask

   task automatic t_saturate();
      logic [31:0] d;
      do_reset();
      wr(4'h0, EN);                           // limit 0: every tick ends a period
      repeat (4100 * 16) @(posedge clk);
      wr(4'h0, 0);
      rd(4'hC, d); check("R9 saturated", d, 32'hFFF0_0000);
      rd(4'h8, d); check("R9 value at max", d, 32'hFFF0_0000);
      rd(4'hC, d); check("R9 cleared after ack", d, 32'h0000_0000);
   endtask

   initial begin
      t_reset();
      t_mode();
      t_period();
      t_coincide();
      t_disable();
      t_saturate();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule